// File: doc/BRIEF.md
# Overcurrent Pulse-Skip and Latch Controller

This block protects one synchronous buck channel against sustained overcurrent. It is stepped by a strobe, `sampleTick`, which arrives once per switching period at the moment the low-side current sample is valid. On each strobe it reads `ocTrip`, the output of an external overcurrent comparator. It drives `hsPulseEn`, which gates the regulation loop's high-side gate pulse. When `hsPulseEn` is low, the high-side pulse is suppressed and the low-side switch keeps conducting.

The first trip opens a two-part window counted in sample strobes, with the first-trip strobe counted as strobe 1. Strobes 1 to 8 form the skip part: every tripped sample suppresses the next high-side pulse, and every clean sample releases it. Strobes 9 to 16 form the guard part: any trip in this part locks the channel off. If the guard part passes with no trip, the block returns to idle after strobe 16. Only a power-on reset, or both channel enables held low together, clears the lock. The length of each part is a parameter.

Top module: `ocp_guard`

## Requirements
- R1: While `rstN` is low and after its release, `hsPulseEn` is 1 and `ocLatched` is 0 until the first sample strobe.
- R2: In idle, a strobe with `ocTrip`=0 leaves `hsPulseEn` at 1 and does not open a window.
- R3: A strobe with `ocTrip`=1 drives `hsPulseEn` to 0 on the clock edge that samples it, and the value holds until the next strobe.
- R4: On strobes 2 to 8 of a window, a trip only suppresses the pulse (`hsPulseEn`=0, `ocLatched`=0), and a clean sample sets `hsPulseEn` back to 1 on that edge.
- R5: A trip on any strobe from 9 to 16 of a window sets `ocLatched` to 1 and `hsPulseEn` to 0 on that edge.
- R6: If strobes 9 to 16 carry no trip, the window closes after strobe 16, and a trip on strobe 17 opens a new window at strobe 1 rather than locking.
- R7: While locked, `ocLatched` stays 1 and `hsPulseEn` stays 0 whatever the strobes and samples.
- R8: The lock and any open window are cleared, with `hsPulseEn`=1 and `ocLatched`=0 on the next edge, only when `enA` and `enB` are both 0 in the same cycle. A single low enable has no effect.
- R9: `ocTrip` is ignored in cycles without `sampleTick`.
- R10: Both enables low in the middle of a window aborts that window, so a later trip opens a fresh window at strobe 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| enA | input | 1 | First channel enable |
| enB | input | 1 | Second channel enable |
| sampleTick | input | 1 | One-cycle strobe marking a valid current sample |
| ocTrip | input | 1 | Overcurrent comparator result, read only on a strobe |
| hsPulseEn | output | 1 | High-side pulse permit for the regulation loop |
| ocLatched | output | 1 | Channel locked off by overcurrent |

## Verification
The case hardest to reach from the ports is the edge of each window part. The lock must fire on strobe 9 and on strobe 16, and a trip on strobe 17 must instead open a new window. Reaching these cases needs exact strobe counts with idle cycles between strobes. The stimulus places comparator trips in those idle cycles to show they are not counted. Each scenario is driven through that exact sequence, and a behavioural model tracks the strobe index. The same sequences are run with the enables dropped one at a time and then together partway through a guard part.

// File: rtl/ocp_guard_pkg.sv
package ocp_guard_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SKIP,
    ST_GUARD,
    ST_LOCK
  } ocpState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic pulseLoad;
    logic pulseVal;
  } ocpStrobe_t;

endpackage

// File: rtl/ocp_window_dp.sv
module ocp_window_dp
  import ocp_guard_pkg::*;
#(
  parameter int SKIP_TICKS  = 8,
  parameter int GUARD_TICKS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  ocpStrobe_t strb,
  output logic       skipLast,
  output logic       guardLast,
  output logic       hsPulseEn
);

  localparam int CNT_W = $clog2(SKIP_TICKS + GUARD_TICKS + 1);
  localparam logic [CNT_W-1:0] SKIP_END  = CNT_W'(SKIP_TICKS - 1);
  localparam logic [CNT_W-1:0] GUARD_END = CNT_W'(SKIP_TICKS + GUARD_TICKS - 1);

  logic [CNT_W-1:0] cntQ;
  logic             pulseQ;

  // strobe counter since the first trip
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.cntClear) begin
      cntQ <= '0;
    end else if (strb.cntStep) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  // registered high-side permit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseQ <= 1'b1;
    end else if (strb.pulseLoad) begin
      pulseQ <= strb.pulseVal;
    end
  end

  assign skipLast  = (cntQ == SKIP_END);
  assign guardLast = (cntQ == GUARD_END);
  assign hsPulseEn = pulseQ;

endmodule

// File: rtl/ocp_window_ctrl.sv
module ocp_window_ctrl
  import ocp_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enA,
  input  logic       enB,
  input  logic       sampleTick,
  input  logic       ocTrip,
  input  logic       skipLast,
  input  logic       guardLast,
  output ocpStrobe_t strb,
  output logic       ocLatched
);

  ocpState_e stQ, stNext;
  logic      bothLow;

  assign bothLow = !enA && !enB;

  always_comb begin
    stNext = stQ;
    strb   = '0;
    if (bothLow) begin
      stNext         = ST_IDLE;
      strb.cntClear  = 1'b1;
      strb.pulseLoad = 1'b1;
      strb.pulseVal  = 1'b1;
    end else if (sampleTick) begin
      unique case (stQ)
        ST_IDLE: begin
          strb.pulseLoad = 1'b1;
          strb.pulseVal  = !ocTrip;
          if (ocTrip) begin
            stNext       = ST_SKIP;
            strb.cntStep = 1'b1;
          end
        end
        ST_SKIP: begin
          strb.pulseLoad = 1'b1;
          strb.pulseVal  = !ocTrip;
          strb.cntStep   = 1'b1;
          if (skipLast) stNext = ST_GUARD;
        end
        ST_GUARD: begin
          strb.pulseLoad = 1'b1;
          if (ocTrip) begin
            stNext        = ST_LOCK;
            strb.cntClear = 1'b1;
            strb.pulseVal = 1'b0;
          end else begin
            strb.pulseVal = 1'b1;
            if (guardLast) begin
              stNext        = ST_IDLE;
              strb.cntClear = 1'b1;
            end else begin
              strb.cntStep = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stNext;
  end

  assign ocLatched = (stQ == ST_LOCK);

endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
  import ocp_guard_pkg::*;
#(
  parameter int SKIP_TICKS  = 8,  // must be 2 or more
  parameter int GUARD_TICKS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic enA,
  input  logic enB,
  input  logic sampleTick,
  input  logic ocTrip,
  output logic hsPulseEn,
  output logic ocLatched
);

  ocpStrobe_t strb;
  logic       skipLast;
  logic       guardLast;

  ocp_window_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enA       (enA),
    .enB       (enB),
    .sampleTick(sampleTick),
    .ocTrip    (ocTrip),
    .skipLast  (skipLast),
    .guardLast (guardLast),
    .strb      (strb),
    .ocLatched (ocLatched)
  );

  ocp_window_dp #(
    .SKIP_TICKS (SKIP_TICKS),
    .GUARD_TICKS(GUARD_TICKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .skipLast (skipLast),
    .guardLast(guardLast),
    .hsPulseEn(hsPulseEn)
  );

endmodule

// File: rtl/ocp_guard_chk.sv
module ocp_guard_chk (
  input logic clk,
  input logic rstN,
  input logic enA,
  input logic enB,
  input logic sampleTick,
  input logic ocTrip,
  input logic hsPulseEn,
  input logic ocLatched
);

  logic bothLow;
  assign bothLow = !enA && !enB;

  // R7: a locked channel never permits a high-side pulse
  a_r7_lock_blocks: assert property (@(posedge clk) disable iff (!rstN)
    ocLatched |-> !hsPulseEn);

  // R7: the lock persists until both enables drop
  a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ocLatched && !bothLow) |=> ocLatched);

  // R8: both enables low clears everything
  a_r8_dual_clear: assert property (@(posedge clk) disable iff (!rstN)
    bothLow |=> (!ocLatched && hsPulseEn));

  // R3: a sampled trip blocks the next pulse
  a_r3_trip_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && ocTrip && !bothLow) |=> !hsPulseEn);

  // R9: without a strobe the permit does not move
  a_r9_no_strobe_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleTick && !bothLow) |=> $stable(hsPulseEn));

  // R5: the lock only rises on a strobe that saw a trip
  a_r5_lock_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ocLatched) |-> $past(sampleTick && ocTrip));

endmodule

bind ocp_guard ocp_guard_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enA       (enA),
  .enB       (enB),
  .sampleTick(sampleTick),
  .ocTrip    (ocTrip),
  .hsPulseEn (hsPulseEn),
  .ocLatched (ocLatched)
);

// File: tb/sim_ocp_guard.sv
`timescale 1ns/1ps
module sim_ocp_guard;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enA = 1'b1, enB = 1'b1, sampleTick = 1'b0, ocTrip = 1'b0;
  logic hsPulseEn, ocLatched;

  int checks = 0;
  int bad = 0;

  // behavioural reference: index of the last strobe in the window
  int  winPos = 0;
  bit  mLatched = 0;
  bit  mPulse = 1;

  always #2 clk = ~clk;

  ocp_guard u0 (
    .clk(clk), .rstN(rstN), .enA(enA), .enB(enB),
    .sampleTick(sampleTick), .ocTrip(ocTrip),
    .hsPulseEn(hsPulseEn), .ocLatched(ocLatched)
  );

  task automatic compare(input string tag);
    checks++;
    if (hsPulseEn !== mPulse || ocLatched !== mLatched) begin
      bad++;
      $display("FAIL %s: got pulse=%b latched=%b expected pulse=%b latched=%b",
               tag, hsPulseEn, ocLatched, mPulse, mLatched);
    end
  endtask

  task automatic modelStep(input bit a, input bit b, input bit tk, input bit tr);
    if (!a && !b) begin
      winPos = 0; mLatched = 0; mPulse = 1;
    end else if (!mLatched && tk) begin
      if (winPos == 0) begin
        mPulse = !tr;
        if (tr) winPos = 1;
      end else begin
        winPos++;
        if (winPos <= 8) begin
          mPulse = !tr;
        end else if (tr) begin
          mLatched = 1; mPulse = 0; winPos = 0;
        end else begin
          mPulse = 1;
          if (winPos == 16) winPos = 0;
        end
      end
    end
  endtask

  // drive at negedge, model the coming edge, check at the next negedge
  task automatic step(input bit a, input bit b, input bit tk, input bit tr, input string tag);
    enA = a; enB = b; sampleTick = tk; ocTrip = tr;
    modelStep(a, b, tk, tr);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic tick(input bit tr, input string tag);
    step(1, 1, 1, tr, tag);
  endtask

  // non-strobe cycle with the comparator asserted
  task automatic gap(input string tag);
    step(1, 1, 0, 1, tag);
  endtask

  task automatic cleanTicks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick(0, tag);
      gap(tag);
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: clean strobes in idle
    cleanTicks(3, "R2");

    // R3: first trip, then gaps carrying trips (R9)
    tick(1, "R3");
    gap("R9");
    gap("R9");
    // skip part, strobes 2..8
    tick(0, "R4"); tick(1, "R4"); tick(1, "R4"); tick(0, "R4");
    tick(1, "R4"); tick(1, "R4"); tick(1, "R4");
    // guard part, strobes 9..16 clean, gaps with trips ignored
    cleanTicks(8, "R9");
    // strobe 17 trip opens a new window
    tick(1, "R6");
    cleanTicks(7, "R6");
    tick(1, "R5");  // strobe 9 locks

    // R7: lock ignores further samples
    tick(0, "R7"); tick(1, "R7"); gap("R7"); tick(0, "R7");
    // R8: single enable low does nothing, both low clears
    step(0, 1, 1, 0, "R8");
    step(1, 0, 1, 1, "R8");
    step(0, 0, 0, 0, "R8");
    tick(0, "R8");

    // R5 boundary: trip on strobe 16
    tick(1, "R5");
    cleanTicks(7, "R4");
    cleanTicks(7, "R5");
    tick(1, "R5");
    step(0, 0, 0, 0, "R8");

    // R6 boundary: full clean window then trip on strobe 17
    tick(1, "R6");
    cleanTicks(15, "R6");
    tick(1, "R6");
    cleanTicks(11, "R10");
    // R10: abort in the guard part
    step(0, 0, 1, 1, "R10");
    tick(1, "R10");
    tick(1, "R10");
    cleanTicks(3, "R10");

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule